// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block is the digital control core of a five-stage step attenuator. It turns one of three programming styles into a registered 5-bit attenuation code. Each bit of the code switches one binary-weighted stage. In serial programming an 8-bit word is shifted in on its own clock and then committed with a latch-enable pulse. In latched-parallel programming five control pins are captured by a latch-enable pulse. In direct-parallel programming latch-enable is tied high and the code tracks the pins.

The serial shifter runs in the serial clock domain. Every other input is synchronised into the system clock domain, and the code register lives there too. After reset the code is forced to maximum attenuation for a programmable number of system-clock cycles. After that window, direct mode takes the pin value, while the other modes wait for a first latched word. The block also raises a sticky flag when a committed serial word has a reserved bit set, and gives a one-cycle strobe each time the code changes.

Top module: `atten_ctrl`

## Requirements
- R1: `mode_serial` low selects the parallel pins as the source of latched values. `mode_serial` high selects the serial shift word as the source.
- R2: The serial shifter is 8 bits wide. It samples `ser_data` on each rising edge of `ser_clk`. The first bit shifted in ends up in word bit 0 and the eighth bit ends up in word bit 7.
- R3: In serial mode, a rising edge of `latch_en` loads word bits 5..1 into `atten_code` bits 4..0.
- R4: While `latch_en` is low, `atten_code` holds its value, whatever happens on the pins, on `ser_data` or on `ser_clk`.
- R5: Code bit 0 weighs 0.5 dB, bit 1 weighs 1 dB, bit 2 weighs 2 dB, bit 3 weighs 4 dB and bit 4 weighs 8 dB. In parallel mode, pin `par_bits[i]` drives code bit i. 0x00 is the minimum-loss state and 0x1F is 15.5 dB.
- R6: In parallel mode with `latch_en` high (direct mode), `atten_code` follows `par_bits`.
- R7: In parallel mode, a high-then-low pulse on `latch_en` leaves `atten_code` holding the pin value present when the pulse ended.
- R8: Reset sets `atten_code` to 0x1F, and the code stays at 0x1F during the power-up window whatever the inputs do.
- R9: The power-up window lasts `PUP_CYCLES` system-clock cycles after reset release. When it ends, a direct-mode setup takes the pin value.
- R10: In serial or latched-parallel mode, the code stays at 0x1F after the window until a word is latched.
- R11: `word_fault` is set by any committed serial word with bit 0, 6 or 7 high, and stays set until reset. Bits 5..1 of that word are still applied.
- R12: `updated` is high for exactly one cycle, in the first cycle that a new code value is visible. It stays low when a latched value equals the current code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for synchronisers, code register and power-up counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, LSB first |
| latch_en | input | 1 | Latch enable shared by all modes |
| mode_serial | input | 1 | 1 selects serial, 0 selects parallel |
| par_bits | input | 5 | Parallel control pins, bit 0 = 0.5 dB |
| atten_code | output | 5 | Registered attenuation code |
| updated | output | 1 | One-cycle strobe on each code change |
| word_fault | output | 1 | Sticky reserved-bit flag for serial words |

## Verification
If the shifter holds the wrong order or a wrong bit, the error shows up only at the next serial commit. It appears as a wrong code about three system cycles after `latch_en` rises, and a wrong reserved bit also shows as a spurious `word_fault`. If the power-up counter misbehaves, the code leaves 0x1F early or late around cycle `PUP_CYCLES`. The bench samples on both sides of that point. If the code register is wrong, it shows at once as a code that drifts while `latch_en` is low, or as a missing or extra `updated` pulse. The bench counts those pulses over each scenario.

// File: rtl/atten_pkg.sv
`timescale 1ns/1ps
package atten_pkg;
  localparam int CODE_W    = 5;
  localparam int WORD_W    = 8;
  localparam int FIELD_LSB = 1;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [WORD_W-1:0] word_t;
  localparam code_t CODE_MAX = '1;
endpackage

// File: rtl/atten_sync.sv
`timescale 1ns/1ps
module atten_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/atten_shift.sv
`timescale 1ns/1ps
module atten_shift
  import atten_pkg::*;
(
  input  logic  ser_clk,
  input  logic  rst_n,
  input  logic  ser_data,
  output word_t word
);
  word_t word_d;

  always_comb word_d = {ser_data, word[WORD_W-1:1]};

  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) word <= '0;
    else word <= word_d;
  end
endmodule

// File: rtl/atten_pup.sv
`timescale 1ns/1ps
module atten_pup #(
  parameter int CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done;
    if (!done) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      done  <= done_d;
    end
  end
endmodule

// File: rtl/atten_ctrl.sv
`timescale 1ns/1ps
module atten_ctrl
  import atten_pkg::*;
#(
  parameter int PUP_CYCLES  = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              latch_en,
  input  logic              mode_serial,
  input  logic [CODE_W-1:0] par_bits,
  output logic [CODE_W-1:0] atten_code,
  output logic              updated,
  output logic              word_fault
);
  localparam int IN_W = CODE_W + 2;

  logic       rst_meta_q, rst_sync_n;
  logic [IN_W-1:0] in_raw, in_s;
  logic       le_s, mode_s, le_prev_q, le_rise, pup_done;
  code_t      par_s, atten_q, atten_d;
  word_t      ser_word;
  logic       fault_q, fault_d, upd_q, upd_d, resv_hit;

  // reset: asserted at once, released on clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  atten_shift u_shift (
    .ser_clk (ser_clk),
    .rst_n   (rst_n),
    .ser_data(ser_data),
    .word    (ser_word)
  );

  assign in_raw = {latch_en, mode_serial, par_bits};

  atten_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d    (in_raw),
    .q    (in_s)
  );

  assign le_s   = in_s[IN_W-1];
  assign mode_s = in_s[IN_W-2];
  assign par_s  = in_s[CODE_W-1:0];

  atten_pup #(.CYCLES(PUP_CYCLES)) u_pup (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .done (pup_done)
  );

  assign le_rise  = le_s & ~le_prev_q;
  assign resv_hit = ser_word[0] | (|ser_word[WORD_W-1:FIELD_LSB+CODE_W]);

  always_comb begin
    atten_d = atten_q;
    fault_d = fault_q;
    if (pup_done) begin
      if (mode_s) begin
        if (le_rise) begin
          atten_d = ser_word[FIELD_LSB +: CODE_W];
          if (resv_hit) fault_d = 1'b1;
        end
      end else if (le_s) begin
        atten_d = par_s;
      end
    end
    upd_d = (atten_d != atten_q);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      atten_q   <= CODE_MAX;
      fault_q   <= 1'b0;
      upd_q     <= 1'b0;
      le_prev_q <= 1'b0;
    end else begin
      atten_q   <= atten_d;
      fault_q   <= fault_d;
      upd_q     <= upd_d;
      le_prev_q <= le_s;
    end
  end

  assign atten_code = atten_q;
  assign updated    = upd_q;
  assign word_fault = fault_q;
endmodule

// File: rtl/atten_ctrl_chk.sv
`timescale 1ns/1ps
module atten_ctrl_chk
  import atten_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input code_t atten_code,
  input logic  updated,
  input logic  word_fault,
  input logic  pup_done,
  input logic  le_s,
  input logic  mode_s,
  input code_t par_s
);
  AST_PUP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    !pup_done |-> atten_code == CODE_MAX); // R8

  AST_HOLD_LE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pup_done && !le_s) |=> $stable(atten_code)); // R4

  AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pup_done && !mode_s && le_s) |=> atten_code == $past(par_s)); // R6

  AST_UPD_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    updated == (atten_code != $past(atten_code))); // R12

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    word_fault |=> word_fault); // R11
endmodule

bind atten_ctrl atten_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .atten_code(atten_code),
  .updated   (updated),
  .word_fault(word_fault),
  .pup_done  (pup_done),
  .le_s      (le_s),
  .mode_s    (mode_s),
  .par_s     (par_s)
);

// File: tb/atten_ctrl_bench.sv
`timescale 1ns/1ps
module atten_ctrl_bench;
  localparam int PUP = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_data = 1'b0;
  logic       latch_en = 1'b0;
  logic       mode_serial = 1'b0;
  logic [4:0] par_bits = '0;
  logic [4:0] atten_code;
  logic       updated, word_fault;

  int checks = 0;
  int failures = 0;
  int upd_count = 0;

  always #2 clk = ~clk;

  atten_ctrl #(.PUP_CYCLES(PUP)) u_atten_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_clk    (ser_clk),
    .ser_data   (ser_data),
    .latch_en   (latch_en),
    .mode_serial(mode_serial),
    .par_bits   (par_bits),
    .atten_code (atten_code),
    .updated    (updated),
    .word_fault (word_fault)
  );

  always @(negedge clk) if (updated) upd_count++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic ms, logic le, logic [4:0] pins);
    rst_n = 1'b0; mode_serial = ms; latch_en = le; par_bits = pins;
    cycles(3);
    rst_n = 1'b1;
  endtask

  task automatic shift_word(logic [7:0] w);
    for (int i = 0; i < 8; i++) begin
      ser_data = w[i];
      #3 ser_clk = 1'b1;
      #3 ser_clk = 1'b0;
    end
  endtask

  task automatic le_pulse();
    latch_en = 1'b1; cycles(6);
    latch_en = 1'b0; cycles(6);
  endtask

  // R8 R9: forced maximum through the window, then direct-mode pins
  task automatic t_powerup_direct();
    do_reset(1'b0, 1'b1, 5'h05);
    chk("R8 reset code", atten_code, 5'h1F);
    chk("R8 reset fault", word_fault, 0);
    upd_count = 0;
    cycles(PUP - 8);
    chk("R8 held in window", atten_code, 5'h1F);
    par_bits = 5'h0A;
    cycles(20);
    chk("R9 direct after window", atten_code, 5'h0A);
    chk("R12 one strobe after window", upd_count, 1);
  endtask

  // R10: serial and latched modes wait for a word
  task automatic t_powerup_wait();
    do_reset(1'b1, 1'b0, 5'h03);
    cycles(PUP + 20);
    chk("R10 serial waits", atten_code, 5'h1F);
    do_reset(1'b0, 1'b0, 5'h03);
    cycles(PUP + 20);
    chk("R10 latched waits", atten_code, 5'h1F);
  endtask

  // R2 R3 R4 R11 R12: serial commits
  task automatic t_serial();
    mode_serial = 1'b1; cycles(6);
    shift_word(8'h32);
    upd_count = 0;
    le_pulse();
    chk("R3 12.5 dB word", atten_code, 5'h19);
    chk("R12 one strobe", upd_count, 1);
    chk("R11 clean word", word_fault, 0);
    shift_word(8'h3E);
    par_bits = 5'h11;
    cycles(10);
    chk("R4 hold while LE low", atten_code, 5'h19);
    le_pulse();
    chk("R2 full word", atten_code, 5'h1F);
    shift_word(8'hCB);
    le_pulse();
    chk("R11 bits applied", atten_code, 5'h05);
    chk("R11 fault set", word_fault, 1);
    shift_word(8'h14);
    le_pulse();
    chk("R11 fault sticky", word_fault, 1);
    chk("R2 order", atten_code, 5'h0A);
    upd_count = 0;
    le_pulse();
    chk("R12 no strobe on equal", upd_count, 0);
  endtask

  // R1 R5 R6 R7: parallel modes and source select
  task automatic t_parallel();
    mode_serial = 1'b0; par_bits = 5'h03; cycles(6);
    shift_word(8'h3E);
    le_pulse();
    chk("R1 parallel source", atten_code, 5'h03);
    mode_serial = 1'b1; cycles(6);
    le_pulse();
    chk("R1 serial source", atten_code, 5'h1F);
    mode_serial = 1'b0; par_bits = 5'h11; cycles(6);
    le_pulse();
    par_bits = 5'h06; cycles(10);
    chk("R7 latched capture", atten_code, 5'h11);
    latch_en = 1'b1;
    for (int b = 0; b < 5; b++) begin
      par_bits = 5'(1 << b); cycles(6);
      chk("R5 weight bit", atten_code, 1 << b);
    end
    par_bits = 5'h00; cycles(6);
    chk("R6 minimum loss", atten_code, 5'h00);
    par_bits = 5'h1F; cycles(6);
    chk("R6 maximum", atten_code, 5'h1F);
    latch_en = 1'b0; cycles(6);
  endtask

  initial begin
    t_powerup_direct();
    t_powerup_wait();
    t_serial();
    t_parallel();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    checks++; failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule